// File: doc/BRIEF.md
# Per-core interrupt acknowledge and completion interface

This block sits between a shared interrupt distributor and one processor core. Each cycle the distributor offers its best pending candidate: a valid flag, a 10-bit source ID and a priority. The block compares that priority against a programmable threshold. While the interface is enabled, no interrupt is in service, and the candidate passes the threshold, the block holds an active-high request level towards the core.

Software on the core talks to the block through a small register port. The port has read and write strobes, a 2-bit address and a 10-bit write bus. The address map is:

| Address | Access | Function |
|---|---|---|
| 0 | write | Control. Bit 0 enables the interface. |
| 1 | write | Priority threshold, held in the low `PRIO_W` bits. |
| 2 | read | Acknowledge. |
| 3 | write | Completion. |

Reading the acknowledge address returns the candidate ID in the same cycle and places that ID in service. The block then pulses an output that tells the state tracker to mark the ID active. If no eligible candidate exists, the read returns the reserved ID 1023. Writing the in-service ID to the completion address ends the service. The block then pulses a second output carrying that ID, so the tracker can retire it.

Only one interrupt is ever in service. The next one is requested only after completion.

Top module: `irq_cpu_if`

## Requirements
- R1: After reset the interface is disabled and the threshold is 0. While the enable bit (bit 0 written to address 0) is 0, `irq_o` stays low and an acknowledge read returns 1023.
- R2: A candidate is eligible only if its priority value is numerically lower than the threshold written to address 1. A lower value means more urgent. A priority equal to or above the threshold gives no request.
- R3: A read at address 2 with an eligible candidate and nothing in service has two effects in that same cycle. It returns the candidate ID on `reg_rdata_o`, and it pulses `mark_act_o` with `mark_id_o` equal to that ID.
- R4: An acknowledge read with no eligible candidate returns 1023 and gives no `mark_act_o` pulse. A candidate whose ID is 1023 is never eligible.
- R5: While an interrupt is in service, `irq_o` is low. A further acknowledge read during that time returns 1023 and gives no pulse.
- R6: A write to address 3 whose data equals the in-service ID does three things:
  - it pulses `mark_done_o` in that cycle, with `done_id_o` equal to the ID;
  - it ends the service;
  - it lets `irq_o` rise again from the next cycle if a candidate is eligible.
- R7: A completion write has no effect if its ID differs from the in-service ID, or if nothing is in service. It gives no pulse, the service continues, and `irq_o` stays low.
- R8: A read of any address other than 2 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid_i | input | 1 | The distributor offers a candidate |
| cand_id_i | input | 10 | Candidate source ID |
| cand_prio_i | input | PRIO_W | Candidate priority; lower value is more urgent |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Read data, valid in the same cycle as the read strobe |
| irq_o | output | 1 | Interrupt request level to the core |
| mark_act_o | output | 1 | Pulse: mark `mark_id_o` active |
| mark_id_o | output | 10 | ID being placed in service |
| mark_done_o | output | 1 | Pulse: mark `done_id_o` completed |
| done_id_o | output | 10 | ID being retired |

## Verification
The embedded properties check several rules on every cycle:
- the request never rises while the interface is disabled or the priority fails the threshold;
- an acknowledge pulse always leaves the matching ID in service;
- a service ends only through a matching completion pulse;
- an acknowledge that finds nothing eligible returns 1023;
- a mismatched completion never pulses.

Other behaviour needs the bench's scenarios to show it. These include the exact IDs returned across a sequence of acknowledges, and the request rising again after completion. They also include the boundary where the priority equals the threshold, and the rejection of a candidate carrying ID 1023.

// File: rtl/irq_cpu_if_pkg.sv
package irq_cpu_if_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = {ID_W{1'b1}};

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_PMASK = 2'd1,
    A_ACK   = 2'd2,
    A_EOI   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cif_cfg_regs.sv
module cif_cfg_regs
  import irq_cpu_if_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [PRIO_W-1:0] wdata_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] pmask_o
);
  logic              en_q, en_d;
  logic [PRIO_W-1:0] pm_q, pm_d;
  logic              cfg_we;

  assign cfg_we = wr_i && ((addr_i == A_CTRL) || (addr_i == A_PMASK));

  always_comb begin
    en_d = en_q;
    pm_d = pm_q;
    if (wr_i && addr_i == A_CTRL)  en_d = wdata_i[0];
    if (wr_i && addr_i == A_PMASK) pm_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      pm_q <= '0;
    end else if (cfg_we) begin
      en_q <= en_d;
      pm_q <= pm_d;
    end
  end

  assign en_o    = en_q;
  assign pmask_o = pm_q;
endmodule

// File: rtl/cif_gate.sv
module cif_gate
  import irq_cpu_if_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              en_i,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] pmask_i,
  output logic              eligible_o
);
  logic prio_ok;
  logic id_ok;

  assign prio_ok    = cand_prio_i < pmask_i;
  assign id_ok      = cand_id_i != SPURIOUS_ID;
  assign eligible_o = en_i && cand_valid_i && prio_ok && id_ok;
endmodule

// File: rtl/cif_active.sv
module cif_active
  import irq_cpu_if_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eligible_i,
  input  logic [ID_W-1:0] cand_id_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [1:0]      addr_i,
  input  logic [ID_W-1:0] wdata_i,
  output logic            busy_o,
  output logic [ID_W-1:0] ack_data_o,
  output logic            mark_act_o,
  output logic [ID_W-1:0] mark_id_o,
  output logic            mark_done_o,
  output logic [ID_W-1:0] done_id_o
);
  logic            act_v_q, act_v_d;
  logic [ID_W-1:0] act_id_q, act_id_d;
  logic            ack_hit, eoi_hit, act_we;

  assign ack_hit = rd_i && (addr_i == A_ACK) && eligible_i && !act_v_q;
  assign eoi_hit = wr_i && (addr_i == A_EOI) && act_v_q && (wdata_i == act_id_q);
  assign act_we  = ack_hit || eoi_hit;

  always_comb begin
    act_v_d  = act_v_q;
    act_id_d = act_id_q;
    if (ack_hit) begin
      act_v_d  = 1'b1;
      act_id_d = cand_id_i;
    end else if (eoi_hit) begin
      act_v_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_v_q  <= 1'b0;
      act_id_q <= SPURIOUS_ID;
    end else if (act_we) begin
      act_v_q  <= act_v_d;
      act_id_q <= act_id_d;
    end
  end

  assign busy_o      = act_v_q;
  assign ack_data_o  = ack_hit ? cand_id_i : SPURIOUS_ID;
  assign mark_act_o  = ack_hit;
  assign mark_id_o   = cand_id_i;
  assign mark_done_o = eoi_hit;
  assign done_id_o   = act_id_q;

  // R3: an acknowledge pulse leaves exactly that ID in service
  assert_ack_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mark_act_o |=> act_v_q && act_id_q == $past(mark_id_o));

  // R5: a service persists, unchanged, until a completion pulse
  assert_single_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_v_q && !mark_done_o |=> act_v_q && $stable(act_id_q));

  // R6: a completion pulse ends the service
  assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mark_done_o |=> !act_v_q);

  // R4: acknowledge with nothing eligible returns the reserved ID
  assert_idle_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i && addr_i == A_ACK && !eligible_i |-> ack_data_o == SPURIOUS_ID && !mark_act_o);

  // R7: a mismatched completion never pulses
  assert_eoi_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i && addr_i == A_EOI && wdata_i != act_id_q |-> !mark_done_o);
endmodule

// File: rtl/irq_cpu_if.sv
module irq_cpu_if
  import irq_cpu_if_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [ID_W-1:0]   reg_wdata_i,
  output logic [ID_W-1:0]   reg_rdata_o,
  output logic              irq_o,
  output logic              mark_act_o,
  output logic [ID_W-1:0]   mark_id_o,
  output logic              mark_done_o,
  output logic [ID_W-1:0]   done_id_o
);
  logic              en;
  logic [PRIO_W-1:0] pmask;
  logic              eligible;
  logic              busy;
  logic [ID_W-1:0]   ack_data;

  cif_cfg_regs #(.PRIO_W(PRIO_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i[PRIO_W-1:0]),
    .en_o    (en),
    .pmask_o (pmask)
  );

  cif_gate #(.PRIO_W(PRIO_W)) u_gate (
    .en_i         (en),
    .cand_valid_i (cand_valid_i),
    .cand_id_i    (cand_id_i),
    .cand_prio_i  (cand_prio_i),
    .pmask_i      (pmask),
    .eligible_o   (eligible)
  );

  cif_active u_act (
    .clk         (clk),
    .rst_n       (rst_n),
    .eligible_i  (eligible),
    .cand_id_i   (cand_id_i),
    .rd_i        (reg_rd_i),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .busy_o      (busy),
    .ack_data_o  (ack_data),
    .mark_act_o  (mark_act_o),
    .mark_id_o   (mark_id_o),
    .mark_done_o (mark_done_o),
    .done_id_o   (done_id_o)
  );

  assign irq_o       = eligible && !busy;
  assign reg_rdata_o = (reg_rd_i && reg_addr_i == A_ACK) ? ack_data : '0;

  // R1: no request while the interface is disabled
  assert_irq_needs_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en);

  // R2: a request implies the priority beats the threshold
  assert_irq_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cand_valid_i && cand_prio_i < pmask);

  // R5: no request while an interrupt is in service
  assert_irq_quiet_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq_o);
endmodule

// File: tb/irq_cpu_if_bench.sv
`timescale 1ns/1ps
module irq_cpu_if_bench;
  localparam int PRIO_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cand_valid;
  logic [9:0]        cand_id;
  logic [PRIO_W-1:0] cand_prio;
  logic              reg_rd, reg_wr;
  logic [1:0]        reg_addr;
  logic [9:0]        reg_wdata;
  logic [9:0]        reg_rdata;
  logic              irq, mark_act, mark_done;
  logic [9:0]        mark_id, done_id;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [9:0] id;
    logic       pulse;
    string      tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  logic       seen_done;
  logic [9:0] seen_done_id;

  always #2 clk = ~clk;

  irq_cpu_if #(.PRIO_W(PRIO_W)) u_irq_cpu_if (
    .clk          (clk),
    .rst_n        (rst_n),
    .cand_valid_i (cand_valid),
    .cand_id_i    (cand_id),
    .cand_prio_i  (cand_prio),
    .reg_rd_i     (reg_rd),
    .reg_wr_i     (reg_wr),
    .reg_addr_i   (reg_addr),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .irq_o        (irq),
    .mark_act_o   (mark_act),
    .mark_id_o    (mark_id),
    .mark_done_o  (mark_done),
    .done_id_o    (done_id)
  );

  task automatic chk(input int act, input int expv, input string tag);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: pops expected acknowledge results as reads happen
  always @(negedge clk) begin
    #1;
    if (reg_rd && reg_addr == 2'd2) begin
      if (exp_q.size() == 0) begin
        chk(1, 0, "unexpected acknowledge read");
      end else begin
        cur = exp_q.pop_front();
        chk(int'(reg_rdata), int'(cur.id), {cur.tag, " read data"});
        chk(int'(mark_act), int'(cur.pulse), {cur.tag, " mark pulse"});
        if (cur.pulse) chk(int'(mark_id), int'(cur.id), {cur.tag, " mark id"});
      end
    end
  end

  // Driver: acknowledge read with an expected scoreboard item
  task automatic ack_read(input logic [9:0] eid, input logic ep, input string tag);
    @(negedge clk);
    reg_rd   = 1'b1;
    reg_addr = 2'd2;
    exp_q.push_back('{id: eid, pulse: ep, tag: tag});
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    #1;
    seen_done    = mark_done;
    seen_done_id = done_id;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_cand(input logic v, input logic [9:0] id, input logic [PRIO_W-1:0] p);
    @(negedge clk);
    cand_valid = v;
    cand_id    = id;
    cand_prio  = p;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    #1;
    chk(int'(irq), int'(e), tag);
  endtask

  task automatic read_other(input logic [1:0] a, input string tag);
    @(negedge clk);
    reg_rd   = 1'b1;
    reg_addr = a;
    #1;
    chk(int'(reg_rdata), 0, tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual 0 expected 1 (run did not complete)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cand_valid = 1'b1; cand_id = 10'd40; cand_prio = 4'd3;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state - disabled, threshold 0
    chk_irq(1'b0, "R1 irq low after reset");
    ack_read(10'd1023, 1'b0, "R1 ack while disabled");
    write_reg(2'd1, 10'd8);
    chk_irq(1'b0, "R1 irq low with threshold set but disabled");
    write_reg(2'd0, 10'd1);
    chk_irq(1'b1, "R1 irq high once enabled");

    // R2: threshold boundary
    set_cand(1'b1, 10'd40, 4'd8);
    chk_irq(1'b0, "R2 priority equal to threshold");
    set_cand(1'b1, 10'd40, 4'd12);
    chk_irq(1'b0, "R2 priority above threshold");
    set_cand(1'b1, 10'd40, 4'd7);
    chk_irq(1'b1, "R2 priority just under threshold");
    set_cand(1'b0, 10'd40, 4'd1);
    chk_irq(1'b0, "R2 no candidate valid");
    set_cand(1'b1, 10'd40, 4'd3);

    // R8: other addresses read as zero
    read_other(2'd0, "R8 read of control address");
    read_other(2'd3, "R8 read of completion address");

    // R3: acknowledge
    ack_read(10'd40, 1'b1, "R3 ack returns candidate");
    // R5: single service
    chk_irq(1'b0, "R5 irq low while in service");
    set_cand(1'b1, 10'd77, 4'd0);
    ack_read(10'd1023, 1'b0, "R5 second ack while in service");
    chk_irq(1'b0, "R5 irq stays low with new candidate");

    // R7: mismatched completion
    write_reg(2'd3, 10'd41);
    chk(int'(seen_done), 0, "R7 mismatched completion gives no pulse");
    chk_irq(1'b0, "R7 service continues after mismatch");
    ack_read(10'd1023, 1'b0, "R7 still busy after mismatch");

    // R6: matching completion
    write_reg(2'd3, 10'd40);
    chk(int'(seen_done), 1, "R6 completion pulse");
    chk(int'(seen_done_id), 40, "R6 completion id");
    chk_irq(1'b1, "R6 irq rises after completion");
    ack_read(10'd77, 1'b1, "R6 next ack after completion");
    write_reg(2'd3, 10'd77);
    chk(int'(seen_done), 1, "R6 second completion pulse");
    chk(int'(seen_done_id), 77, "R6 second completion id");

    // R7: completion with nothing in service
    write_reg(2'd3, 10'd77);
    chk(int'(seen_done), 0, "R7 completion while idle");

    // R4: reserved ID never eligible, idle ack
    set_cand(1'b1, 10'd1023, 4'd1);
    chk_irq(1'b0, "R4 candidate with reserved id");
    ack_read(10'd1023, 1'b0, "R4 ack with reserved-id candidate");
    set_cand(1'b0, 10'd5, 4'd1);
    ack_read(10'd1023, 1'b0, "R4 ack with no candidate");

    // R3 with a high ID, then R1 disable
    set_cand(1'b1, 10'd1022, 4'd0);
    ack_read(10'd1022, 1'b1, "R3 ack of highest legal id");
    write_reg(2'd3, 10'd1022);
    chk(int'(seen_done_id), 1022, "R6 completion of highest legal id");
    write_reg(2'd0, 10'd0);
    chk_irq(1'b0, "R1 irq low after disable");
    ack_read(10'd1023, 1'b0, "R1 ack after disable");

    repeat (2) @(negedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule